// File: doc/BRIEF.md
# Deblocking Edge-Order Schedule Controller

This controller walks one macroblock through the filtering of its edges in an order that mixes vertical and horizontal edges inside each half of the block. Pixels being worked on stay in a small set of local subblock buffers, so the block never writes a partial result back to the unfiltered-pixel store and reads it again in the other direction. Every cycle it says which store to read or write and which local buffer is in use. For a filter cycle it also gives the edge direction. The pixel stores and the filter arithmetic sit outside the block.

A one-cycle `start` pulse launches a macroblock. The controller handles the luma plane first, stalls for the data-hazard gap, and then handles the two chroma planes. Each plane is done as an upper half and then a lower half. Each half is a buffer fill followed by eight time indexes, and every time index filters one edge. Results that later serve as upper neighbours go to the neighbour store. All other results go to external memory. A one-cycle `done` pulse follows the last write. The unfiltered-pixel store is double-banked, and the bank select changes with every completion. The same sequence serves both the in-loop and the post-loop filter configurations, so no mode input is needed.

Top module: `dbs_sched_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `bank` and every request output (`cm_rd`, `sm_rd`, `sm_wr`, `ext_wr`, `filt_en`) are 0. A reset applied during a macroblock returns the block to this state.
- R2: A macroblock keeps `busy` high for exactly 243 cycles. These start in the cycle after `start` is sampled. In the cycle after the last busy cycle, `done` is high for one cycle and `busy` is low.
- R3: Each half opens with 4 buffer-fill cycles. In these cycles `cm_rd`=1, `filt_en`=0, and `buf_sel` is one-hot, selecting buffers 0, 1, 2, 3 in turn (bit k means buffer k).
- R4: A half then runs time indexes t=0..7. Edge t lasts 8 cycles in luma and 2 cycles in chroma, with `filt_en`=1. When t is even, `edge_dir`=0 (vertical) and `cm_rd`=1. When t is odd, `edge_dir`=1 (horizontal) and `sm_rd`=1. In every filter cycle `buf_sel` selects buffer t/2.
- R5: Number the edges e = 8*half + t + 1, where `half` is 0 for upper and 1 for lower. For e in {6, 10, 14, 16}, the filter cycles are followed by neighbour-store write cycles: 3 per edge in luma and 1 per edge in chroma. In these cycles `sm_wr`=1, `filt_en`=0, `ext_wr`=0, and `buf_sel` stays on buffer t/2.
- R6: Every other edge raises `ext_wr` in its last filter cycle only. This gives 36 external writes per macroblock.
- R7: Between the luma lower half and the first chroma half there are exactly 7 stall cycles. In these cycles `busy`=1 and every request output and `buf_sel` are 0.
- R8: The plane order is luma (`plane`=0), then chroma 1 (`plane`=1), then chroma 2 (`plane`=2). Each plane runs upper half (`half`=0) before lower half (`half`=1).
- R9: `bank` holds steady through a macroblock and inverts in the cycle in which `done` is high.
- R10: A `start` that arrives while `busy` is high is ignored. A `start` that arrives in the `done` cycle launches the next macroblock at once.
- R11: At most one of `cm_rd`, `sm_rd` and `sm_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one macroblock (accepted only when idle) |
| busy | output | 1 | Macroblock in progress |
| done | output | 1 | One-cycle completion pulse |
| bank | output | 1 | Bank of the unfiltered-pixel store being read |
| plane | output | 2 | 0 luma, 1 chroma 1, 2 chroma 2 |
| half | output | 1 | 0 upper half, 1 lower half |
| time_idx | output | 3 | Time index within the half |
| filt_en | output | 1 | Filter cycle |
| edge_dir | output | 1 | 0 vertical, 1 horizontal (only when filt_en) |
| buf_sel | output | 4 | One-hot local buffer select |
| cm_rd | output | 1 | Read request to the unfiltered-pixel store |
| sm_rd | output | 1 | Read request to the neighbour store |
| sm_wr | output | 1 | Write request to the neighbour store |
| ext_wr | output | 1 | Write request to external memory |

## Verification
Two events can fall in the same cycle: the completion of one macroblock, with its `done` pulse and bank inversion, and the launch of the next. The bench raises `start` exactly in the `done` cycle. It then expects the next cycle to be the first buffer fill of a new luma upper half with the bank already inverted, and no idle cycle in between. A second case drives `start` in the middle of a busy run. Here the cycle-by-cycle sequence and the 243-cycle length must remain unchanged.

// File: rtl/dbs_pkg.sv
// Shared types for the deblocking schedule controller.
// Assumes: three planes per macroblock, luma first.
package dbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOAD  = 3'd1,
        PH_FILT  = 3'd2,
        PH_SWR   = 3'd3,
        PH_STALL = 3'd4
    } phase_t;

    typedef enum logic [1:0] {
        PL_Y  = 2'd0,
        PL_C1 = 2'd1,
        PL_C2 = 2'd2
    } plane_t;

endpackage

// File: rtl/dbs_seq.sv
// Phase sequencer: walks planes, halves, buffer fills, edges,
// neighbour-store writes and the hazard stall.
// Assumes: slice_edge_i is decoded combinationally from the current state.
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int NUM_BUF    = 4,
    parameter int TIDX_N     = 8,
    parameter int Y_EDGE_CYC = 8,
    parameter int C_EDGE_CYC = 2,
    parameter int Y_SW_CYC   = 3,
    parameter int C_SW_CYC   = 1,
    parameter int HAZ_CYC    = 7,
    localparam int TW   = $clog2(TIDX_N),
    localparam int M1   = (NUM_BUF > Y_EDGE_CYC) ? NUM_BUF : Y_EDGE_CYC,
    localparam int M2   = (M1 > HAZ_CYC) ? M1 : HAZ_CYC,
    localparam int M3   = (M2 > Y_SW_CYC) ? M2 : Y_SW_CYC,
    localparam int MAXC = (M3 > 2) ? M3 : 2,
    localparam int CW   = $clog2(MAXC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          slice_edge_i,
    output phase_t        ph_o,
    output plane_t        plane_o,
    output logic          half_o,
    output logic [TW-1:0] tidx_o,
    output logic [CW-1:0] cnt_o,
    output logic          filt_fin_o,
    output logic          mb_end_o,
    output logic          done_o
);

    phase_t        ph_q, ph_n;
    plane_t        plane_q, plane_n;
    logic          half_q, half_n;
    logic [TW-1:0] tidx_q, tidx_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          done_q;
    logic [CW-1:0] ecyc_m1, swc_m1;
    logic          filt_fin, edge_end, half_end, mb_end;

    // Purpose: end-of-step conditions for the current phase.
    always_comb begin
        ecyc_m1  = (plane_q == PL_Y) ? CW'(Y_EDGE_CYC - 1) : CW'(C_EDGE_CYC - 1);
        swc_m1   = (plane_q == PL_Y) ? CW'(Y_SW_CYC - 1)   : CW'(C_SW_CYC - 1);
        filt_fin = (ph_q == PH_FILT) && (cnt_q == ecyc_m1);
        edge_end = (filt_fin && !slice_edge_i) ||
                   ((ph_q == PH_SWR) && (cnt_q == swc_m1));
        half_end = edge_end && (tidx_q == TW'(TIDX_N - 1));
        mb_end   = half_end && half_q && (plane_q == PL_C2);
    end

    // Purpose: next-state selection for the phase walk.
    always_comb begin
        ph_n    = ph_q;
        plane_n = plane_q;
        half_n  = half_q;
        tidx_n  = tidx_q;
        cnt_n   = cnt_q + 1'b1;
        case (ph_q)
            PH_IDLE: begin
                cnt_n = '0;
                if (start_i) begin
                    ph_n    = PH_LOAD;
                    plane_n = PL_Y;
                    half_n  = 1'b0;
                    tidx_n  = '0;
                end
            end
            PH_LOAD: begin
                if (cnt_q == CW'(NUM_BUF - 1)) begin
                    ph_n   = PH_FILT;
                    cnt_n  = '0;
                    tidx_n = '0;
                end
            end
            PH_FILT, PH_SWR: begin
                if (filt_fin && slice_edge_i) begin
                    ph_n  = PH_SWR;
                    cnt_n = '0;
                end else if (edge_end) begin
                    cnt_n = '0;
                    if (!half_end) begin
                        ph_n   = PH_FILT;
                        tidx_n = tidx_q + 1'b1;
                    end else if (!half_q) begin
                        ph_n   = PH_LOAD;
                        half_n = 1'b1;
                    end else if (plane_q == PL_Y) begin
                        ph_n = PH_STALL;
                    end else if (plane_q == PL_C1) begin
                        ph_n    = PH_LOAD;
                        plane_n = PL_C2;
                        half_n  = 1'b0;
                    end else begin
                        ph_n = PH_IDLE;
                    end
                end
            end
            PH_STALL: begin
                if (cnt_q == CW'(HAZ_CYC - 1)) begin
                    ph_n    = PH_LOAD;
                    plane_n = PL_C1;
                    half_n  = 1'b0;
                    cnt_n   = '0;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            plane_q <= PL_Y;
            half_q  <= 1'b0;
            tidx_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            ph_q    <= ph_n;
            plane_q <= plane_n;
            half_q  <= half_n;
            tidx_q  <= tidx_n;
            cnt_q   <= cnt_n;
            done_q  <= mb_end;
        end
    end

    assign ph_o       = ph_q;
    assign plane_o    = plane_q;
    assign half_o     = half_q;
    assign tidx_o     = tidx_q;
    assign cnt_o      = cnt_q;
    assign filt_fin_o = filt_fin;
    assign mb_end_o   = mb_end;
    assign done_o     = done_q;

endmodule

// File: rtl/dbs_decode.sv
// Output decoder: turns the sequencer state into memory requests,
// buffer select and edge direction. Also flags the edges whose results
// are kept as upper neighbours.
// Assumes: TIDX_N is a multiple of NUM_BUF.
module dbs_decode
    import dbs_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int TIDX_N  = 8,
    parameter int CW      = 3,
    localparam int TW  = $clog2(TIDX_N),
    localparam int EPB = TIDX_N / NUM_BUF
) (
    input  phase_t             ph_i,
    input  logic               half_i,
    input  logic [TW-1:0]      tidx_i,
    input  logic [CW-1:0]      cnt_i,
    input  logic               filt_fin_i,
    output logic               slice_edge_o,
    output logic               filt_en_o,
    output logic               edge_dir_o,
    output logic               cm_rd_o,
    output logic               sm_rd_o,
    output logic               sm_wr_o,
    output logic               ext_wr_o,
    output logic [NUM_BUF-1:0] buf_sel_o
);

    int edge_num;

    // Purpose: edge numbering and detection of the neighbour-kept edges.
    always_comb begin
        edge_num     = (half_i ? TIDX_N : 0) + int'(tidx_i) + 1;
        slice_edge_o = (edge_num == 6) || (edge_num == 10) ||
                       (edge_num == 14) || (edge_num == 16);
    end

    // Purpose: request, direction and buffer select per phase.
    always_comb begin
        filt_en_o  = (ph_i == PH_FILT);
        edge_dir_o = filt_en_o && tidx_i[0];
        cm_rd_o    = (ph_i == PH_LOAD) || (filt_en_o && !tidx_i[0]);
        sm_rd_o    = filt_en_o && tidx_i[0];
        sm_wr_o    = (ph_i == PH_SWR);
        ext_wr_o   = filt_fin_i && !slice_edge_o;
        buf_sel_o  = '0;
        if (ph_i == PH_LOAD) begin
            buf_sel_o[int'(cnt_i) % NUM_BUF] = 1'b1;
        end else if ((ph_i == PH_FILT) || (ph_i == PH_SWR)) begin
            buf_sel_o[int'(tidx_i) / EPB] = 1'b1;
        end
    end

endmodule

// File: rtl/dbs_bank.sv
// Ping-pong bank select for the unfiltered-pixel store.
// Assumes: flip_i is high for one cycle at the end of a macroblock.
module dbs_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    output logic bank_o
);

    // Purpose: invert the bank at each macroblock end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_o <= 1'b0;
        end else if (flip_i) begin
            bank_o <= ~bank_o;
        end
    end

endmodule

// File: rtl/dbs_sched_ctrl.sv
// Top of the deblocking edge-order schedule controller.
// Wires the sequencer, the output decoder and the bank select together.
// Assumes: the external stores accept one request per cycle without backpressure.
module dbs_sched_ctrl
    import dbs_pkg::*;
#(
    parameter int NUM_BUF    = 4,
    parameter int TIDX_N     = 8,
    parameter int Y_EDGE_CYC = 8,
    parameter int C_EDGE_CYC = 2,
    parameter int Y_SW_CYC   = 3,
    parameter int C_SW_CYC   = 1,
    parameter int HAZ_CYC    = 7,
    localparam int TW   = $clog2(TIDX_N),
    localparam int M1   = (NUM_BUF > Y_EDGE_CYC) ? NUM_BUF : Y_EDGE_CYC,
    localparam int M2   = (M1 > HAZ_CYC) ? M1 : HAZ_CYC,
    localparam int M3   = (M2 > Y_SW_CYC) ? M2 : Y_SW_CYC,
    localparam int MAXC = (M3 > 2) ? M3 : 2,
    localparam int CW   = $clog2(MAXC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               bank,
    output logic [1:0]         plane,
    output logic               half,
    output logic [TW-1:0]      time_idx,
    output logic               filt_en,
    output logic               edge_dir,
    output logic [NUM_BUF-1:0] buf_sel,
    output logic               cm_rd,
    output logic               sm_rd,
    output logic               sm_wr,
    output logic               ext_wr
);

    phase_t        ph;
    plane_t        plane_s;
    logic [CW-1:0] cnt;
    logic          filt_fin, mb_end, slice_edge;

    dbs_seq #(
        .NUM_BUF(NUM_BUF), .TIDX_N(TIDX_N),
        .Y_EDGE_CYC(Y_EDGE_CYC), .C_EDGE_CYC(C_EDGE_CYC),
        .Y_SW_CYC(Y_SW_CYC), .C_SW_CYC(C_SW_CYC), .HAZ_CYC(HAZ_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .slice_edge_i(slice_edge),
        .ph_o(ph), .plane_o(plane_s), .half_o(half), .tidx_o(time_idx),
        .cnt_o(cnt), .filt_fin_o(filt_fin), .mb_end_o(mb_end), .done_o(done)
    );

    dbs_decode #(.NUM_BUF(NUM_BUF), .TIDX_N(TIDX_N), .CW(CW)) u_dec (
        .ph_i(ph), .half_i(half), .tidx_i(time_idx), .cnt_i(cnt),
        .filt_fin_i(filt_fin), .slice_edge_o(slice_edge),
        .filt_en_o(filt_en), .edge_dir_o(edge_dir), .cm_rd_o(cm_rd),
        .sm_rd_o(sm_rd), .sm_wr_o(sm_wr), .ext_wr_o(ext_wr), .buf_sel_o(buf_sel)
    );

    dbs_bank u_bank (.clk(clk), .rst_n(rst_n), .flip_i(mb_end), .bank_o(bank));

    assign busy  = (ph != PH_IDLE);
    assign plane = plane_s;

endmodule

// File: rtl/dbs_sched_ctrl_chk.sv
// Port-level property checker for dbs_sched_ctrl, attached by bind.
// Assumes: the same parameter values as the bound instance.
module dbs_sched_ctrl_chk #(
    parameter int NUM_BUF = 4,
    parameter int TIDX_N  = 8,
    localparam int TW = $clog2(TIDX_N)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               bank,
    input logic [1:0]         plane,
    input logic               half,
    input logic [TW-1:0]      time_idx,
    input logic               filt_en,
    input logic               edge_dir,
    input logic [NUM_BUF-1:0] buf_sel,
    input logic               cm_rd,
    input logic               sm_rd,
    input logic               sm_wr,
    input logic               ext_wr
);

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_BUF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_sel)); // R3
    AST_VERT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !edge_dir) |-> cm_rd); // R4
    AST_HORZ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && edge_dir) |-> sm_rd); // R4
    AST_SWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sm_wr |-> (!filt_en && !ext_wr)); // R5
    AST_EXT_IN_FILT: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr |-> filt_en); // R6
    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bank)); // R9
    AST_LAUNCH_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_rd, sm_rd, sm_wr})); // R11

endmodule

bind dbs_sched_ctrl dbs_sched_ctrl_chk #(.NUM_BUF(NUM_BUF), .TIDX_N(TIDX_N)) u_chk (.*);

// File: tb/dbs_sched_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: sweeps whole macroblocks and compares every cycle against a
// schedule built from nested loops over planes, halves and edges.
module dbs_sched_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, bank, half, filt_en, edge_dir;
    logic       cm_rd, sm_rd, sm_wr, ext_wr;
    logic [1:0] plane;
    logic [2:0] time_idx;
    logic [3:0] buf_sel;

    int checks = 0;
    int errors = 0;
    int cyc_n;
    int ext_n;
    int start_at;
    logic exp_bank = 1'b0;

    always #2 clk = ~clk;

    dbs_sched_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .bank(bank), .plane(plane), .half(half), .time_idx(time_idx),
        .filt_en(filt_en), .edge_dir(edge_dir), .buf_sel(buf_sel),
        .cm_rd(cm_rd), .sm_rd(sm_rd), .sm_wr(sm_wr), .ext_wr(ext_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One busy cycle: compare, count, optionally poke start, advance.
    task automatic step(input string tag, input logic e_cm, input logic e_sm,
                        input logic e_sw, input logic e_ext, input logic e_f,
                        input logic e_dir, input logic [3:0] e_buf,
                        input logic [1:0] e_pl, input logic e_h);
        chk(tag,
            {18'd0, busy, done, bank, cm_rd, sm_rd, sm_wr, ext_wr, filt_en, edge_dir, buf_sel, plane, half},
            {18'd0, 1'b1, 1'b0, exp_bank, e_cm, e_sm, e_sw, e_ext, e_f, e_dir, e_buf, e_pl, e_h});
        if (ext_wr) ext_n++;
        cyc_n++;
        start = (cyc_n == start_at);
        @(negedge clk);
    endtask

    // Full macroblock; first busy cycle visible on entry.
    task automatic run_mb(input bit chain, input int poke);
        int ec, sc, e;
        bit sw;
        cyc_n = 0;
        ext_n = 0;
        start_at = poke;
        for (int pl = 0; pl < 3; pl++) begin
            if (pl == 1) begin
                for (int s = 0; s < 7; s++)
                    step("R7", 0, 0, 0, 0, 0, 0, 4'd0, 2'd0, 1'b1);
            end
            ec = (pl == 0) ? 8 : 2;
            sc = (pl == 0) ? 3 : 1;
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < 4; k++)
                    step("R3", 1, 0, 0, 0, 0, 0, 4'(1 << k), 2'(pl), 1'(h));
                for (int t = 0; t < 8; t++) begin
                    e  = h * 8 + t + 1;
                    sw = (e == 6) || (e == 10) || (e == 14) || (e == 16);
                    for (int c = 0; c < ec; c++)
                        step((c == ec - 1) ? "R6" : "R4", !t[0], t[0], 0,
                             (c == ec - 1) && !sw, 1, t[0], 4'(1 << (t / 2)), 2'(pl), 1'(h));
                    if (sw)
                        for (int c = 0; c < sc; c++)
                            step("R5", 0, 0, 1, 0, 0, 0, 4'(1 << (t / 2)), 2'(pl), 1'(h));
                end
            end
        end
        // done cycle
        exp_bank = ~exp_bank;
        chk("R2 length", 32'(cyc_n), 32'd243);
        chk("R6 ext count", 32'(ext_n), 32'd36);
        chk("R2 done", {30'd0, done, busy}, {30'd0, 1'b1, 1'b0});
        chk("R9 bank flip", {31'd0, bank}, {31'd0, exp_bank});
        chk("R11 quiet", {28'd0, cm_rd, sm_rd, sm_wr, ext_wr}, 32'd0);
        start = chain;
        @(negedge clk);
        start = 1'b0;
        if (!chain) chk("R2 done pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", {26'd0, busy, done, bank, cm_rd, sm_rd, sm_wr},
            32'd0);
        chk("R1 reset req", {30'd0, ext_wr, filt_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {31'd0, busy}, 32'd0);
        // R10: launch, poke start mid-run, chain a start on done
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run_mb(1'b1, 50);
        run_mb(1'b0, 160);
        repeat (3) @(negedge clk);
        chk("R10 stays idle", {30'd0, busy, done}, 32'd0);
        // R1: reset in the middle of a macroblock
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 mid luma", {30'd0, plane}, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_bank = 1'b0;
        chk("R1 mid reset", {27'd0, busy, done, bank, cm_rd, filt_en}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule